// File: doc/BRIEF.md
# FEC Lane Status Serializer

This block turns two wide, slowly changing status vectors into two narrow buses that a monitor can read one word at a time. The first vector holds a 2-bit lane mapping code for each of the four lanes of six FEC instances. The second holds a 15-bit alignment delay, counted in unit intervals, for each of the 24 physical lanes.

The mapping bus carries one instance per cycle as an 8-bit word, so a full round takes 6 cycles. The delay bus carries one lane per cycle, so a full round takes 24 cycles. Each bus has its own single-cycle sync pulse, which marks the slot that carries the first element of a round. The two slot counters run freely from reset and do not depend on each other.

At the edge that emits slot 0, the block copies the whole input into a shadow register. Every word of a round therefore comes from one snapshot. While `enable` is low, both buses and both syncs read zero, and the counters keep running.

Top module: `fec_lane_stat_mux`

## Requirements
- R1: In the cycle where `map_sync` is high, `map_bus` carries instance 0. The following cycles carry instances 1, 2, 3, 4 and 5 in order, and then the round repeats.
- R2: `map_sync` is a single-cycle pulse that repeats every 6 cycles.
- R3: In a mapping word, lane L sits in bits [2L+1:2L]. Lane (i, L) is read from `map_in[(4i+L)*2 +: 2]`.
- R4: In the cycle where `dly_sync` is high, `dly_bus` carries instance 0 lane 0. Slot k carries instance k/4, lane k%4, read from `dly_in[k*15 +: 15]`.
- R5: `dly_sync` is a single-cycle pulse that repeats every 24 cycles.
- R6: Each delay value reaches the bus as an unchanged 15-bit number.
- R7: While `rst_n` is low, all outputs are zero. The first clock edge after reset is released emits slot 0 on both buses, with both syncs high.
- R8: Both inputs are sampled only at the edge that emits slot 0 of their round. If an input changes in the middle of a round, the change appears only from the next round on.
- R9: While `enable` is low, both buses and both syncs are zero. The slot counters keep running, so when `enable` returns the buses resume in the same phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Output enable; when low, all outputs are forced to zero |
| map_in | input | 48 | Lane mapping codes, 2 bits per (instance, lane) |
| dly_in | input | 360 | Alignment delays in UI, 15 bits per lane |
| map_bus | output | 8 | Mapping word of the current instance |
| map_sync | output | 1 | High on the instance-0 slot |
| dly_bus | output | 15 | Delay of the current lane |
| dly_sync | output | 1 | High on the instance-0 lane-0 slot |

## Verification
The bench builds the block with its default values: six instances, four lanes, 2-bit codes and 15-bit delays. At that size, every slot of both rounds is compared in every cycle over more than six delay rounds, so each slot position is covered several times. The input patterns are arithmetic functions of a seed. The bench changes the seed in the middle of a round, which exercises the shadow snapshot. It also drops `enable` for a window that does not line up with either round boundary, so the bench can confirm that both buses come back in phase.

// File: rtl/fec_stat_pkg.sv
package fec_stat_pkg;
   localparam int unsigned DEF_INST  = 6;
   localparam int unsigned DEF_LANE  = 4;
   localparam int unsigned DEF_MAP_W = 2;
   localparam int unsigned DEF_DLY_W = 15;

   // width of a counter that holds 0 .. n-1
   function automatic int unsigned slot_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/slot_ctr.sv
module slot_ctr
   import fec_stat_pkg::*;
#(
   parameter int unsigned PERIOD = 6,
   parameter int unsigned W      = slot_bits(PERIOD)
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] slot,
   output logic         first
);
   localparam logic [W-1:0] LAST = W'(PERIOD - 1);

   if (PERIOD < 2) begin : g_bad_period
      $error("slot_ctr: PERIOD must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            slot <= '0;
      else if (slot == LAST) slot <= '0;
      else                   slot <= slot + 1'b1;
   end

   assign first = (slot == '0);
endmodule

// File: rtl/stat_slot_ser.sv
module stat_slot_ser
   import fec_stat_pkg::*;
#(
   parameter int unsigned N_ELEM = 6,
   parameter int unsigned ELEM_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic [N_ELEM*ELEM_W-1:0] par_in,
   output logic [ELEM_W-1:0]        bus,
   output logic                     sync
);
   localparam int unsigned SW    = slot_bits(N_ELEM);
   localparam int unsigned SH_W  = (N_ELEM - 1) * ELEM_W;

   if (N_ELEM < 2) begin : g_bad_elem
      $error("stat_slot_ser: N_ELEM must be at least 2");
   end
   if (ELEM_W < 1) begin : g_bad_width
      $error("stat_slot_ser: ELEM_W must be at least 1");
   end

   logic [SW-1:0]     slot;
   logic              first;
   logic [SH_W-1:0]   shadow;
   logic [ELEM_W-1:0] sel;
   logic [ELEM_W-1:0] bus_q;
   logic              sync_q;
   int unsigned       idx;

   slot_ctr #(.PERIOD(N_ELEM), .W(SW)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .slot  (slot),
      .first (first)
   );

   // element 0 goes straight out; elements 1..N-1 are kept for the round
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     shadow <= '0;
      else if (first) shadow <= par_in[N_ELEM*ELEM_W-1:ELEM_W];
   end

   always_comb begin
      idx = first ? 0 : (int'(slot) - 1);
      if (first) sel = par_in[ELEM_W-1:0];
      else       sel = shadow[idx*ELEM_W +: ELEM_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_q  <= '0;
         sync_q <= 1'b0;
      end else begin
         bus_q  <= sel;
         sync_q <= first;
      end
   end

   assign bus  = en ? bus_q : '0;
   assign sync = en & sync_q;
endmodule

// File: rtl/fec_lane_stat_mux.sv
module fec_lane_stat_mux
   import fec_stat_pkg::*;
#(
   parameter int unsigned N_INST = DEF_INST,
   parameter int unsigned N_LANE = DEF_LANE,
   parameter int unsigned MAP_W  = DEF_MAP_W,
   parameter int unsigned DLY_W  = DEF_DLY_W,
   localparam int unsigned WORD_W = N_LANE * MAP_W,
   localparam int unsigned N_DLY  = N_INST * N_LANE
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      enable,
   input  logic [N_INST*WORD_W-1:0]  map_in,
   input  logic [N_DLY*DLY_W-1:0]    dly_in,
   output logic [WORD_W-1:0]         map_bus,
   output logic                      map_sync,
   output logic [DLY_W-1:0]          dly_bus,
   output logic                      dly_sync
);
   if (N_INST < 2) begin : g_bad_inst
      $error("fec_lane_stat_mux: N_INST must be at least 2");
   end
   if (MAP_W < 1 || DLY_W < 1 || N_LANE < 1) begin : g_bad_fields
      $error("fec_lane_stat_mux: field widths and lane count must be nonzero");
   end

   // assemble one word per instance, lane L in field L
   logic [N_INST*WORD_W-1:0] map_words;
   for (genvar i = 0; i < N_INST; i++) begin : g_inst
      for (genvar l = 0; l < N_LANE; l++) begin : g_lane
         assign map_words[i*WORD_W + l*MAP_W +: MAP_W] =
                map_in[(i*N_LANE + l)*MAP_W +: MAP_W];
      end
   end

   stat_slot_ser #(.N_ELEM(N_INST), .ELEM_W(WORD_W)) u_map_ser (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (enable),
      .par_in (map_words),
      .bus    (map_bus),
      .sync   (map_sync)
   );

   stat_slot_ser #(.N_ELEM(N_DLY), .ELEM_W(DLY_W)) u_dly_ser (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (enable),
      .par_in (dly_in),
      .bus    (dly_bus),
      .sync   (dly_sync)
   );
endmodule

// File: rtl/fec_lane_stat_mux_chk.sv
module fec_lane_stat_mux_chk
   import fec_stat_pkg::*;
#(
   parameter int unsigned N_INST = DEF_INST,
   parameter int unsigned N_DLY  = DEF_INST * DEF_LANE,
   parameter int unsigned WORD_W = DEF_LANE * DEF_MAP_W,
   parameter int unsigned DLY_W  = DEF_DLY_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic [WORD_W-1:0] map_w0,
   input logic [DLY_W-1:0]  dly_w0,
   input logic [WORD_W-1:0] map_bus,
   input logic              map_sync,
   input logic [DLY_W-1:0]  dly_bus,
   input logic              dly_sync
);
   localparam int unsigned MW = slot_bits(N_INST);
   localparam int unsigned DW = slot_bits(N_DLY);

   logic [MW-1:0] m_gap;
   logic [DW-1:0] d_gap;
   logic          m_seen, d_seen;

   // gap counters wrap at the period, so suppressed pulses keep them aligned
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_gap <= '0; d_gap <= '0; m_seen <= 1'b0; d_seen <= 1'b0;
      end else begin
         if (map_sync || m_gap == MW'(N_INST - 1)) m_gap <= '0;
         else                                      m_gap <= m_gap + 1'b1;
         if (dly_sync || d_gap == DW'(N_DLY - 1))  d_gap <= '0;
         else                                      d_gap <= d_gap + 1'b1;
         if (map_sync) m_seen <= 1'b1;
         if (dly_sync) d_seen <= 1'b1;
      end
   end

   a_r2_map_sync_period: assert property (@(posedge clk) disable iff (!rst_n)
      (map_sync && m_seen) |-> (m_gap == MW'(N_INST - 1)));

   a_r5_dly_sync_period: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_sync && d_seen) |-> (d_gap == DW'(N_DLY - 1)));

   a_r1_map_first_word: assert property (@(posedge clk) disable iff (!rst_n)
      map_sync |-> (map_bus == $past(map_w0)));

   a_r4_dly_first_lane: assert property (@(posedge clk) disable iff (!rst_n)
      dly_sync |-> (dly_bus == $past(dly_w0)));

   a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (map_bus == '0 && !map_sync && dly_bus == '0 && !dly_sync));

   a_r2_map_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
      map_sync |=> !map_sync);
endmodule

bind fec_lane_stat_mux fec_lane_stat_mux_chk #(
   .N_INST (N_INST),
   .N_DLY  (N_DLY),
   .WORD_W (WORD_W),
   .DLY_W  (DLY_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .map_w0   (map_in[WORD_W-1:0]),
   .dly_w0   (dly_in[DLY_W-1:0]),
   .map_bus  (map_bus),
   .map_sync (map_sync),
   .dly_bus  (dly_bus),
   .dly_sync (dly_sync)
);

// File: tb/fec_lane_stat_mux_test.sv
`timescale 1ns/1ps
module fec_lane_stat_mux_test;
   localparam int NI = 6, NL = 4, MW = 2, DWD = 15;
   localparam int NW = NL * MW;
   localparam int ND = NI * NL;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               enable = 1'b1;
   logic [NI*NW-1:0]   map_in = '0;
   logic [ND*DWD-1:0]  dly_in = '0;
   logic [NW-1:0]      map_bus;
   logic               map_sync;
   logic [DWD-1:0]     dly_bus;
   logic               dly_sync;

   int checks = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   fec_lane_stat_mux uut (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .map_in(map_in), .dly_in(dly_in),
      .map_bus(map_bus), .map_sync(map_sync),
      .dly_bus(dly_bus), .dly_sync(dly_sync)
   );

   function automatic int mval(int seed, int i, int l);
      return (i*3 + l + seed) % 4;
   endfunction

   function automatic int dval(int seed, int k);
      return (seed*1237 + k*2111 + k*k*7) % 32768;
   endfunction

   int cur_seed = 0;

   task automatic set_inputs(input int seed);
      cur_seed = seed;
      for (int i = 0; i < NI; i++)
         for (int l = 0; l < NL; l++) begin
            map_in[(i*NL + l)*MW +: MW] = MW'(mval(seed, i, l));
            dly_in[(i*NL + l)*DWD +: DWD] = DWD'(dval(seed, i*NL + l));
         end
   endtask

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      int mslot = 0, dslot = 0, mseed = 0;
      logic [NI*NW-1:0]  msh;
      logic [ND*DWD-1:0] dsh;
      int exp_m, exp_d, exp_ms, exp_ds;
      string dtag;

      set_inputs(1);
      repeat (3) @(negedge clk);
      // R7: outputs quiet in reset
      check("R7 map_bus in reset", int'(map_bus), 0);
      check("R7 map_sync in reset", int'(map_sync), 0);
      check("R7 dly_bus in reset", int'(dly_bus), 0);
      check("R7 dly_sync in reset", int'(dly_sync), 0);
      rst_n = 1'b1;

      for (int cyc = 0; cyc < 160; cyc++) begin
         @(posedge clk);
         if (mslot == 0) begin msh = map_in; mseed = cur_seed; end
         if (dslot == 0) dsh = dly_in;
         exp_m  = int'(msh[mslot*NW +: NW]);
         exp_ms = (mslot == 0);
         exp_d  = int'(dsh[dslot*DWD +: DWD]);
         exp_ds = (dslot == 0);
         @(negedge clk);
         if (!enable) begin
            check("R9 map_bus gated", int'(map_bus), 0);
            check("R9 map_sync gated", int'(map_sync), 0);
            check("R9 dly_bus gated", int'(dly_bus), 0);
            check("R9 dly_sync gated", int'(dly_sync), 0);
         end else begin
            dtag = (cyc >= 10 && cyc < 24) ? "R8 dly_bus mid-round hold" : "R4/R6 dly_bus";
            check("R1/R8 map_bus", int'(map_bus), exp_m);
            check("R2/R7 map_sync", int'(map_sync), exp_ms);
            check(dtag, int'(dly_bus), exp_d);
            check("R5/R7 dly_sync", int'(dly_sync), exp_ds);
            if (mslot == 0)
               for (int l = 0; l < NL; l++)
                  check("R3 lane field", int'(map_bus[l*MW +: MW]), mval(mseed, 0, l));
         end
         mslot = (mslot + 1) % NI;
         dslot = (dslot + 1) % ND;
         if (cyc == 10) set_inputs(2);
         if (cyc == 61) enable = 1'b0;
         if (cyc == 73) enable = 1'b1;
         if (cyc == 95) set_inputs(3);
         if (cyc == 130) set_inputs(4);
      end
      finish_run();
   end
endmodule